// File: doc/BRIEF.md
# Memory Component Register File

This block holds the 32-bit cache/memory register region of a memory-expansion component. A host reaches it over a simple request bus: one cycle carries a request flag, a write flag, a byte address, an access size and write data, and read data returns on the following cycle with a valid flag. The region holds a capability header array, a set of RAS error registers and, for component kinds that decode memory, one HDM decoder register set.

Every register has a fixed write mask. A write keeps the masked bits of the new data and the stored value for all other bits, so read-only fields hold. The decoder control register adds a commit handshake. Writing it with the commit request bit set marks the decoder committed, and writing it with that bit clear marks it uncommitted. Either write clears the error flag. A component-kind parameter selects which capabilities exist and how wide the decoder target-list low word may be written.

Top module: `memcomp_regfile`

## Requirements
- R1: Only 4-byte accesses (`size_i` = 4) are serviced. A read of any other size returns 0 and a write of any other size leaves every register unchanged.
- R2: An access whose address is not a multiple of 4 is ignored on write and returns 0 on read.
- R3: A write stores (wdata & mask) | (old & ~mask). Registers with mask 0 never change: the headers at 0x000–0x014, the error capability/control word at 0x054 and the HDM capability at 0x100.
- R4: Decoder control lives at 0x120 with write mask 0x13FF, commit request in bit 9, committed flag in bit 10 and error flag in bit 11. A write stores bit 10 equal to the written bit 9 and stores bit 11 as 0.
- R5: The decoder write masks are as follows. Base low (0x110) and size low (0x118) use 0xF0000000. Base high (0x114), size high (0x11C) and target list high (0x128) use 0xFFFFFFFF. Global control (0x104) uses 0x3. Target list low (0x124) uses 0xF0000000 for device kinds and 0xFFFFFFFF for port kinds.
- R6: The RAS words reset as follows. Uncorrectable status (0x040) resets to 0 with mask 0x1CFFF. Uncorrectable mask (0x044) and severity (0x048) reset to 0x1CFFF with mask 0x1CFFF. Correctable status (0x04C) resets to 0 with mask 0x7F. Correctable mask (0x050) resets to 0x7F with mask 0x7F. Error capability/control (0x054) resets to 0x200.
- R7: The main header at 0x000 holds ID 1 in [15:0], version 1 in [19:16], cache-mem version 1 in [23:20] and the array size in [31:24]. The array size is 2 for downstream ports and plain devices, 3 for upstream ports, memory devices and logical devices, and 5 for root ports. Sub-headers hold ID in [15:0], version in [19:16] and a region offset in [31:20]. RAS is at 0x004 (ID 2, v2, 0x040). Link is at 0x008 (ID 4, v2, 0x080). HDM is at 0x00C (ID 5, v1, 0x100). Extended security is at 0x010 (ID 6, v1, 0x180). Snoop is at 0x014 (ID 8, v1, 0x1A0).
- R8: The HDM capability word reads 0x310. That is a decoder-count code of 0 in [3:0], a target count of 1 in [7:4], 256 B interleave in bit 8, 4 KiB interleave in bit 9 and no poison support in bit 10.
- R9: Offsets with no register, and registers of capabilities absent for the selected kind, read 0 and ignore writes.
- R10: A read request raises `rvalid_o` with its data in the next cycle. In any other cycle `rvalid_o` is low.
- R11: An active-low reset returns every register to its reset value and clears `rvalid_o` and `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset within the region |
| size_i | input | 4 | Access size in bytes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |

## Verification
A corrupted mask or merge shows on the very next read of that register: a read-only field comes back altered, or a writable field fails to take the data. A broken commit handshake shows on the first read-back of the control word after a write, as a wrong committed or error bit. A decode fault shows as non-zero data from an empty offset, or as a write landing on the wrong register. Every such fault surfaces within two cycles of the access that provokes it.

// File: rtl/memcomp_pkg.sv
package memcomp_pkg;
  typedef enum logic [2:0] {
    KIND_DSP, KIND_DEV, KIND_USP, KIND_MEMDEV, KIND_LOGDEV, KIND_RP
  } kind_e;

  localparam int N_SLOTS  = 21;
  localparam int DW       = 32;
  localparam int CMT_B    = 9;
  localparam int CMTD_B   = 10;
  localparam int ERR_B    = 11;
  localparam int CTRL_IDX = 18;

  function automatic int cap_count(kind_e k);
    case (k)
      KIND_DSP, KIND_DEV: return 2;
      KIND_RP:            return 5;
      default:            return 3;
    endcase
  endfunction

  function automatic bit is_device(kind_e k);
    return (k == KIND_DEV) || (k == KIND_MEMDEV) || (k == KIND_LOGDEV);
  endfunction

  function automatic bit slot_present(int i, kind_e k);
    if (i == 4 || i == 5)  return cap_count(k) == 5;
    if (i == 3 || i >= 12) return cap_count(k) >= 3;
    return 1'b1;
  endfunction

  function automatic logic [11:0] slot_addr(int i);
    case (i)
      0: return 12'h000;  1: return 12'h004;  2: return 12'h008;
      3: return 12'h00C;  4: return 12'h010;  5: return 12'h014;
      6: return 12'h040;  7: return 12'h044;  8: return 12'h048;
      9: return 12'h04C; 10: return 12'h050; 11: return 12'h054;
      12: return 12'h100; 13: return 12'h104; 14: return 12'h110;
      15: return 12'h114; 16: return 12'h118; 17: return 12'h11C;
      18: return 12'h120; 19: return 12'h124; default: return 12'h128;
    endcase
  endfunction

  function automatic logic [DW-1:0] main_header(kind_e k);
    return {8'(cap_count(k)), 4'd1, 4'd1, 16'd1};
  endfunction

  function automatic logic [DW-1:0] slot_reset(int i, kind_e k);
    case (i)
      0:     return main_header(k);
      1:     return {12'h040, 4'd2, 16'd2};
      2:     return {12'h080, 4'd2, 16'd4};
      3:     return {12'h100, 4'd1, 16'd5};
      4:     return {12'h180, 4'd1, 16'd6};
      5:     return {12'h1A0, 4'd1, 16'd8};
      7, 8:  return 32'h0001_CFFF;
      10:    return 32'h0000_007F;
      11:    return 32'h0000_0200;
      12:    return 32'h0000_0310;
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] slot_mask(int i, kind_e k);
    case (i)
      6, 7, 8:      return 32'h0001_CFFF;
      9, 10:        return 32'h0000_007F;
      13:           return 32'h0000_0003;
      14, 16:       return 32'hF000_0000;
      15, 17, 20:   return 32'hFFFF_FFFF;
      18:           return 32'h0000_13FF;
      19:           return is_device(k) ? 32'hF000_0000 : 32'hFFFF_FFFF;
      default:      return '0;
    endcase
  endfunction
endpackage

// File: rtl/memcomp_decode.sv
module memcomp_decode
  import memcomp_pkg::*;
#(
  parameter int    ADDR_W = 12,
  parameter kind_e KIND   = KIND_MEMDEV
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        size_i,
  output logic [N_SLOTS-1:0] sel_o
);
  logic ok;
  assign ok = req_i && (size_i == 4'd4) && (addr_i[1:0] == 2'b00);

  always_comb begin
    sel_o = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (slot_present(i, KIND) && ok && (addr_i == ADDR_W'(slot_addr(i))))
        sel_o[i] = 1'b1;
    end
  end
endmodule

// File: rtl/memcomp_slot.sv
module memcomp_slot
  import memcomp_pkg::*;
#(
  parameter logic [DW-1:0] RST    = '0,
  parameter logic [DW-1:0] MASK   = '0,
  parameter bit            CMT_HS = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] nxt;

  always_comb begin
    nxt = (wdata_i & MASK) | (q_o & ~MASK);
    if (CMT_HS) begin
      nxt[ERR_B]  = 1'b0;
      nxt[CMTD_B] = nxt[CMT_B];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (wr_i) q_o <= nxt;
  end
endmodule

// File: rtl/memcomp_regfile.sv
module memcomp_regfile
  import memcomp_pkg::*;
#(
  parameter int    ADDR_W = 12,
  parameter kind_e KIND   = KIND_MEMDEV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        size_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o
);
  logic [N_SLOTS-1:0] sel;
  logic [DW-1:0]      q [N_SLOTS];
  logic [DW-1:0]      rd_mux;
  logic [DW-1:0]      ctrl_q;

  memcomp_decode #(.ADDR_W(ADDR_W), .KIND(KIND)) dec_i (
    .req_i (req_i), .addr_i(addr_i), .size_i(size_i), .sel_o(sel)
  );

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    if (slot_present(g, KIND)) begin : g_on
      memcomp_slot #(
        .RST   (slot_reset(g, KIND)),
        .MASK  (slot_mask(g, KIND)),
        .CMT_HS(g == CTRL_IDX)
      ) slot_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (sel[g] & we_i),
        .wdata_i(wdata_i),
        .q_o    (q[g])
      );
    end else begin : g_off
      assign q[g] = '0;
    end
  end

  assign ctrl_q = q[CTRL_IDX];

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_SLOTS; i++)
      if (sel[i]) rd_mux = rd_mux | q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= req_i & ~we_i;
      if (req_i && !we_i) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/memcomp_regfile_chk.sv
module memcomp_regfile_chk
  import memcomp_pkg::*;
#(
  parameter int    ADDR_W = 12,
  parameter kind_e KIND   = KIND_MEMDEV
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [3:0]        size_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic              rvalid_o,
  input logic [DW-1:0]     ctrl_q
);
  localparam bit            HAS_HDM = cap_count(KIND) >= 3;
  localparam logic [DW-1:0] HDR_EXP = main_header(KIND);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(slot_addr(CTRL_IDX));

  logic rd, wr;
  assign rd = req_i && !we_i;
  assign wr = req_i && we_i;

  assert_rvalid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o);
  assert_rvalid_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !rvalid_o);
  assert_bad_size_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && size_i != 4'd4) |=> rdata_o == '0);
  assert_unaligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i[1:0] != 2'b00) |=> rdata_o == '0);
  assert_header_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && size_i == 4'd4 && addr_i == '0) |=> rdata_o == HDR_EXP);
  assert_ctrl_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(ctrl_q));

  if (HAS_HDM) begin : g_hdm
    assert_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && size_i == 4'd4 && addr_i == CTRL_A)
        |=> (ctrl_q[CMTD_B] == $past(wdata_i[CMT_B])) && !ctrl_q[ERR_B]);
  end
endmodule

bind memcomp_regfile memcomp_regfile_chk #(.ADDR_W(ADDR_W), .KIND(KIND)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .size_i(size_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .rvalid_o(rvalid_o), .ctrl_q(ctrl_q)
);

// File: tb/memcomp_regfile_tb_top.sv
`timescale 1ns/1ps
module memcomp_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [3:0]  size = 4'd4;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  memcomp_regfile dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  task automatic chk(string req_tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req_tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] s = 4'd4);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; size = s;
    @(negedge clk);
    req = 1'b0; we = 1'b0; size = 4'd4;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d, input logic [3:0] s = 4'd4);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; size = s;
    @(negedge clk);
    req = 1'b0; size = 4'd4;
    chk("R10 rvalid", {31'd0, rvalid}, 32'd1);
    d = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 rvalid reset", {31'd0, rvalid}, 32'd0);
    chk("R11 rdata reset", rdata, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_headers();
    logic [31:0] d;
    rd(12'h000, d); chk("R7 main header", d, 32'h0311_0001);
    rd(12'h004, d); chk("R7 ras header", d, 32'h0402_0002);
    rd(12'h008, d); chk("R7 link header", d, 32'h0802_0004);
    rd(12'h00C, d); chk("R7 hdm header", d, 32'h1001_0005);
    rd(12'h010, d); chk("R9 extsec absent", d, 32'h0);
    rd(12'h014, d); chk("R9 snoop absent", d, 32'h0);
    rd(12'h100, d); chk("R8 hdm capability", d, 32'h0000_0310);
  endtask

  task automatic t_ras();
    logic [31:0] d;
    rd(12'h040, d); chk("R6 unc status", d, 32'h0);
    rd(12'h044, d); chk("R6 unc mask", d, 32'h0001_CFFF);
    rd(12'h048, d); chk("R6 unc sev", d, 32'h0001_CFFF);
    rd(12'h04C, d); chk("R6 cor status", d, 32'h0);
    rd(12'h050, d); chk("R6 cor mask", d, 32'h7F);
    rd(12'h054, d); chk("R6 err cap", d, 32'h200);
    wr(12'h044, 32'h0); rd(12'h044, d); chk("R6 unc mask clr", d, 32'h0);
    wr(12'h044, 32'hFFFF_FFFF); rd(12'h044, d); chk("R6 unc mask set", d, 32'h0001_CFFF);
    wr(12'h050, 32'hFFFF_FF00); rd(12'h050, d); chk("R6 cor mask", d, 32'h0);
  endtask

  task automatic t_masks();
    logic [31:0] d;
    wr(12'h000, 32'h0); rd(12'h000, d); chk("R3 ro header", d, 32'h0311_0001);
    wr(12'h054, 32'h0); rd(12'h054, d); chk("R3 ro err cap", d, 32'h200);
    wr(12'h100, 32'h0); rd(12'h100, d); chk("R3 ro hdm cap", d, 32'h310);
    wr(12'h110, 32'hFFFF_FFFF); rd(12'h110, d); chk("R5 base lo", d, 32'hF000_0000);
    wr(12'h114, 32'h1234_5678); rd(12'h114, d); chk("R5 base hi", d, 32'h1234_5678);
    wr(12'h118, 32'h5A5A_5A5A); rd(12'h118, d); chk("R5 size lo", d, 32'h5000_0000);
    wr(12'h11C, 32'hA5A5_A5A5); rd(12'h11C, d); chk("R5 size hi", d, 32'hA5A5_A5A5);
    wr(12'h104, 32'hF); rd(12'h104, d); chk("R5 global ctl", d, 32'h3);
    wr(12'h124, 32'hFFFF_FFFF); rd(12'h124, d); chk("R5 tgt lo device", d, 32'hF000_0000);
    wr(12'h128, 32'hCAFE_F00D); rd(12'h128, d); chk("R5 tgt hi", d, 32'hCAFE_F00D);
  endtask

  task automatic t_commit();
    logic [31:0] d;
    wr(12'h120, 32'hFFFF_FFFF); rd(12'h120, d); chk("R4 commit all", d, 32'h0000_17FF);
    wr(12'h120, 32'h0000_00FF); rd(12'h120, d); chk("R4 uncommit", d, 32'h0000_00FF);
    wr(12'h120, 32'h0000_0A00); rd(12'h120, d); chk("R4 commit err clr", d, 32'h0000_0600);
    wr(12'h120, 32'h0000_0C00); rd(12'h120, d); chk("R4 uncommit ro", d, 32'h0);
  endtask

  task automatic t_size_align();
    logic [31:0] d;
    wr(12'h104, 32'h0);
    wr(12'h104, 32'h3, 4'd8); rd(12'h104, d); chk("R1 wide write ignored", d, 32'h0);
    rd(12'h000, d, 4'd8); chk("R1 wide read zero", d, 32'h0);
    rd(12'h044, d, 4'd2); chk("R1 short read zero", d, 32'h0);
    wr(12'h105, 32'h3); rd(12'h104, d); chk("R2 unaligned write ignored", d, 32'h0);
    rd(12'h001, d); chk("R2 unaligned read zero", d, 32'h0);
  endtask

  task automatic t_holes();
    logic [31:0] d;
    wr(12'h080, 32'hFFFF_FFFF); rd(12'h080, d); chk("R9 link region", d, 32'h0);
    rd(12'h200, d); chk("R9 beyond map", d, 32'h0);
    rd(12'h10C, d); chk("R9 gap", d, 32'h0);
  endtask

  task automatic t_reset_again();
    logic [31:0] d;
    wr(12'h110, 32'hFFFF_FFFF);
    wr(12'h044, 32'h0);
    do_reset();
    rd(12'h110, d); chk("R11 base lo reset", d, 32'h0);
    rd(12'h044, d); chk("R11 unc mask reset", d, 32'h0001_CFFF);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    t_headers();
    t_ras();
    t_masks();
    t_commit();
    t_size_align();
    t_holes();
    t_reset_again();
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule